// File: doc/BRIEF.md
# Single-Clock Fall-Through FIFO with Strobe Control

This block is a small synchronous first-in first-out buffer for one clock domain. Each cycle it performs at most one operation. A strobe, `ce`, marks an active cycle, and a direction flag, `we`, picks a push or a pop. The oldest stored word is always driven on `dout` through combinational logic. A consumer can therefore take the word during the same cycle in which it raises the pop strobe, with no extra latency cycle.

The storage is an array of 2**ADDR_W words with write and read pointers that wrap around. One slot always stays unused, so the occupancy count fits in ADDR_W bits. With the default parameters that gives a 16-word array, a capacity of 15 words and a 4-bit count.

The `empty`, `full` and `size` outputs are registered. They change on the clock edge that completes an accepted operation. A push while full is discarded, and so is a pop while empty. A synchronous reset empties the buffer.

Top module: `strobe_fifo`

## Requirements
- R1: Words accepted with ce=1, we=1 come out on `dout` in the order in which they were written, without corruption.
- R2: During a cycle with ce=1, we=0 and the buffer not empty, `dout` already shows the word being popped before the clock edge that completes the pop.
- R3: `size` rises by one on the edge after an accepted push and falls by one on the edge after an accepted pop.
- R4: `full` is 1 exactly when `size` equals 15 (2**ADDR_W-1). The buffer never holds more than 15 words.
- R5: `empty` is 0 after any accepted push and is 1 exactly when `size` equals 0.
- R6: An accepted pop always leaves `full` at 0 after its edge.
- R7: A push while `full`=1 is ignored. `size` and `full` are unchanged, and the stored words and their order are unchanged.
- R8: A pop while `empty`=1 is ignored. `size` stays 0 and the read position does not move, so the next word pushed is the next word popped.
- R9: With `rst`=1 at a clock edge, `size` becomes 0, `empty` becomes 1 and `full` becomes 0, and all held words are discarded.
- R10: In a cycle with ce=0, `size`, `empty` and `full` keep their values, whatever `we` and `din` do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Operation strobe for this cycle |
| we | input | 1 | With ce=1: 1 selects push, 0 selects pop |
| din | input | 16 | Word to push |
| dout | output | 16 | Oldest held word (don't-care while empty) |
| empty | output | 1 | Registered: no words held |
| full | output | 1 | Registered: 15 words held |
| size | output | 4 | Registered occupancy count |

## Verification
A wrong pointer or array write does not change any flag. It shows up on `dout` only when the affected word reaches the head, which can be up to 15 pops after the fault. The bench therefore checks every popped word against a queue model, and it drains the buffer completely after every overflow test. A wrong count or flag register shows up on the next edge as a mismatch on `size`, `empty` or `full`. The bench checks all three after every single operation, and it also compares them against each other and against the distance between the pointers.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2
  } sfifo_op_e;

  // Strobe pair to operation code.
  function automatic sfifo_op_e decode_op(input logic ce, input logic we);
    if (!ce) return OP_IDLE;
    return we ? OP_WRITE : OP_READ;
  endfunction

endpackage

// File: rtl/sfifo_store.sv
module sfifo_store #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  // Fall-through: head word visible without a clock edge (R2).
  assign rd_data = mem[rd_addr];

endmodule

// File: rtl/sfifo_ctrl.sv
module sfifo_ctrl #(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce,
  input  logic              we,
  output logic              wr_fire,
  output logic              rd_fire,
  output logic [ADDR_W-1:0] wr_ptr,
  output logic [ADDR_W-1:0] rd_ptr,
  output logic [ADDR_W-1:0] count,
  output logic              empty,
  output logic              full
);
  import sfifo_pkg::*;

  localparam int unsigned       DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] CAP   = ADDR_W'(DEPTH - 1);

  // Up/down step on an ADDR_W-bit value, wrapping modulo DEPTH.
  function automatic logic [ADDR_W-1:0] f_step(input logic [ADDR_W-1:0] v,
                                               input logic up, input logic dn);
    return v + ADDR_W'(up) - ADDR_W'(dn);
  endfunction

  sfifo_op_e         op;
  logic [ADDR_W-1:0] count_nxt;

  assign op        = decode_op(ce, we);
  assign wr_fire   = (op == OP_WRITE) && !full;   // R7: drop push when full
  assign rd_fire   = (op == OP_READ)  && !empty;  // R8: drop pop when empty
  assign count_nxt = f_step(count, wr_fire, rd_fire);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      empty  <= 1'b1;
      full   <= 1'b0;
    end else begin
      if (wr_fire) wr_ptr <= f_step(wr_ptr, 1'b1, 1'b0);
      if (rd_fire) rd_ptr <= f_step(rd_ptr, 1'b1, 1'b0);
      if (wr_fire || rd_fire) begin
        count <= count_nxt;
        empty <= (count_nxt == '0);
        full  <= (count_nxt == CAP);
      end
    end
  end

  p_count_up_r3: assert property (@(posedge clk) disable iff (rst)
    wr_fire |=> count == ADDR_W'($past(count) + 1'b1));
  p_count_dn_r3: assert property (@(posedge clk) disable iff (rst)
    rd_fire |=> count == ADDR_W'($past(count) - 1'b1));
  p_ptr_gap_r3: assert property (@(posedge clk) disable iff (rst)
    count == ADDR_W'(wr_ptr - rd_ptr));
  p_full_cap_r4: assert property (@(posedge clk) disable iff (rst)
    full == (count == CAP));
  p_empty_zero_r5: assert property (@(posedge clk) disable iff (rst)
    empty == (count == '0));
  p_rd_clears_full_r6: assert property (@(posedge clk) disable iff (rst)
    rd_fire |=> !full);
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
    (ce && we && full) |=> full && $stable(count) && $stable(wr_ptr));
  p_no_underflow_r8: assert property (@(posedge clk) disable iff (rst)
    (ce && !we && empty) |=> empty && $stable(rd_ptr));
  p_reset_r9: assert property (@(posedge clk)
    rst |=> empty && !full && count == '0);
  p_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !ce |=> $stable(count) && $stable(empty) && $stable(full));

endmodule

// File: rtl/strobe_fifo.sv
module strobe_fifo #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce,
  input  logic              we,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              empty,
  output logic              full,
  output logic [ADDR_W-1:0] size
);
  logic              wr_fire;
  logic              rd_fire;
  logic [ADDR_W-1:0] wr_ptr;
  logic [ADDR_W-1:0] rd_ptr;

  sfifo_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .ce      (ce),
    .we      (we),
    .wr_fire (wr_fire),
    .rd_fire (rd_fire),
    .wr_ptr  (wr_ptr),
    .rd_ptr  (rd_ptr),
    .count   (size),
    .empty   (empty),
    .full    (full)
  );

  sfifo_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
    .clk     (clk),
    .wr_en   (wr_fire),
    .wr_addr (wr_ptr),
    .wr_data (din),
    .rd_addr (rd_ptr),
    .rd_data (dout)
  );

  // R1: a pop never fires in the same cycle as a push.
  p_one_op_r1: assert property (@(posedge clk) disable iff (rst)
    !(wr_fire && rd_fire));

endmodule

// File: tb/sim_strobe_fifo.sv
module sim_strobe_fifo;
  localparam int CLK_PERIOD = 10;
  localparam int CAP        = 15;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ce  = 1'b0;
  logic        we  = 1'b0;
  logic [15:0] din = '0;
  logic [15:0] dout;
  logic        empty, full;
  logic [3:0]  size;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  logic [15:0] model[$];

  strobe_fifo u0 (
    .clk(clk), .rst(rst), .ce(ce), .we(we), .din(din),
    .dout(dout), .empty(empty), .full(full), .size(size)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit exp_full(input int n);
    return n >= CAP;
  endfunction
  function automatic bit exp_empty(input int n);
    return n == 0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_flags(input string tag);
    chk({tag, " size"},  32'(size),  32'(model.size()));
    chk({tag, " empty"}, 32'(empty), 32'(exp_empty(model.size())));
    chk({tag, " full"},  32'(full),  32'(exp_full(model.size())));
  endtask

  // One cycle: drive at negedge, sample dout before the edge, flags after it.
  task automatic cyc(input logic c, input logic w, input logic [15:0] d, input string tag);
    @(negedge clk);
    ce = c; we = w; din = d;
    #1;
    if (c && !w && model.size() > 0)
      chk({tag, " R1/R2 dout"}, 32'(dout), 32'(model[0]));
    @(posedge clk);
    if (c && w && model.size() < CAP) model.push_back(d);
    else if (c && !w && model.size() > 0) void'(model.pop_front());
    #1;
    chk_flags(tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; ce = 1'b0;
    @(posedge clk);
    model.delete();
    #1;
    chk_flags("R9 reset");
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    do_reset();

    // Fill to capacity, then push while full.
    for (int i = 0; i < CAP; i++) cyc(1, 1, 16'(16'h1000 + i), "R3/R4 fill");
    chk("R4 full at 15", 32'(full), 32'd1);
    cyc(1, 1, 16'hDEAD, "R7 push when full");
    cyc(1, 1, 16'hBEEF, "R7 push when full");
    for (int i = 0; i < CAP; i++) cyc(1, 0, 16'h0, "R1/R7 drain");
    chk("R5 empty after drain", 32'(empty), 32'd1);

    // Pops while empty, then a push must be the next word out.
    cyc(1, 0, 16'h0, "R8 pop when empty");
    cyc(1, 0, 16'h0, "R8 pop when empty");
    cyc(1, 1, 16'hA5A5, "R5 push clears empty");
    cyc(1, 0, 16'h0, "R8 next word after empty pop");

    // Full, then one pop clears full.
    for (int i = 0; i < CAP; i++) cyc(1, 1, 16'(i * 16'h0111), "R4 refill");
    cyc(1, 0, 16'h0, "R6 pop clears full");
    chk("R6 full low", 32'(full), 32'd0);

    // Idle cycles with we and din toggling.
    for (int i = 0; i < 6; i++) cyc(0, 1'(i), 16'(i * 16'h3333), "R10 idle");

    // Reset with words held, then confirm old words are gone.
    do_reset();
    cyc(1, 1, 16'h5A5A, "R9 after reset push");
    cyc(1, 0, 16'h0, "R9 after reset pop");

    // Random mix in phases of push-heavy and pop-heavy traffic.
    for (int i = 0; i < 3000; i++) begin
      int pw;
      pw = ((i / 100) % 2 == 0) ? 70 : 30;
      cyc(($urandom % 100) < 85, ($urandom % 100) < pw, 16'($urandom), "R3 random");
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule